// File: doc/BRIEF.md
# Bit-7 Completion Poller for Flash Program and Erase

This block sits on the host side of a parallel flash. Once software has written the last word of a program or erase command sequence, it hands the poller one start request. The request carries the operation kind, the address to poll, and the bit-7 value of the word being programmed. The poller then reads that address again and again over a simple one-outstanding read port. It watches the status bit until the flash reports that the operation has finished. When the operation is a program, the address is the programmed location. When it is an erase, the address lies inside one of the sectors being erased.

The status bit can turn to its final value one read before the rest of the word is valid. For that reason, detection alone does not end the job. After the read that shows completion, the poller waits the idle gap, issues one more read, and returns that word as the result. A programmable read budget ends polling with a timeout indication when completion is never seen.

Both the start and the result use valid/ready handshakes. Start side: `start_ready` is high only while the poller is idle, and a `start_valid` seen while it is low is dropped with no effect. Result side: once `res_valid` rises, it stays high and `res_data`/`res_timeout` stay frozen until the cycle in which `res_ready` is high. The poller returns to idle on the clock edge that completes that handshake, so back-pressure on the result simply keeps the block busy. The read port is plain: `rd_req` is a one-cycle request and `rd_rvalid` is a one-cycle response that may arrive any number of cycles later.

Top module: `datapoll_host_ctrl`

## Requirements
- R1: After reset, `start_ready` is 1, and `rd_req` and `res_valid` are 0.
- R2: A start is taken on a cycle with `start_valid` and `start_ready` both high, and the first `rd_req` appears in the very next cycle. `start_ready` stays 0 from then until the result handshake. A `start_valid` seen while `start_ready` is 0 changes neither the polled address nor the result.
- R3: Every read request lasts one cycle and drives `rd_addr` with the address captured at start. At most one read is outstanding, so no new `rd_req` is issued before the response.
- R4: For a program (`start_erase`=0), a poll read counts as complete when bit 7 of `rd_rdata` equals `start_want`.
- R5: For an erase (`start_erase`=1), a poll read counts as complete when bit 7 of `rd_rdata` is 1; `start_want` is ignored.
- R6: After a completing poll read, exactly one further read is made. `res_data` is the word of that later read, with `res_timeout`=0.
- R7: After every read response that does not end the operation, exactly `GAP_CYC` cycles pass with `rd_req` low before the next request.
- R8: If `poll_limit` poll reads pass without completion, the result is given with `res_timeout`=1 and `res_data`=0. A `poll_limit` of 0 acts as 1. A completion on the last allowed read still wins over the timeout.
- R9: `res_valid` rises in the cycle after the response of the final read. It then holds, with `res_data` and `res_timeout` stable, until a cycle with `res_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Start request |
| start_ready | output | 1 | High while idle; start is taken when both are high |
| start_erase | input | 1 | 1 = erase, 0 = program |
| start_addr | input | ADDR_W | Address to poll |
| start_want | input | 1 | Bit 7 of the word being programmed |
| poll_limit | input | CNT_W | Maximum number of poll reads (0 treated as 1) |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | ADDR_W | Read address |
| rd_rvalid | input | 1 | One-cycle read response strobe |
| rd_rdata | input | DATA_W | Read response word |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result accepted |
| res_data | output | DATA_W | Word from the confirming read, or 0 on timeout |
| res_timeout | output | 1 | 1 when the read budget ran out |

## Verification
Most faults in the controller's state show up at the read port within one read interval. A lost confirm flag shows up as a missing extra read, and the result then carries the word from the detection read. A gap counter that is off by one moves the next `rd_req` early or late by a cycle. A budget count that is wrong sends `res_valid` with `res_timeout` one read too early or too late. A reference model in the bench predicts `rd_req`, `rd_addr`, `start_ready` and the result signals for every cycle, so any of these faults is caught in the cycle it first appears.

// File: rtl/dpoll_pkg.sv
package dpoll_pkg;

  typedef enum logic [2:0] {
    DP_IDLE = 3'd0,
    DP_REQ  = 3'd1,
    DP_WAIT = 3'd2,
    DP_GAP  = 3'd3,
    DP_DONE = 3'd4
  } dp_state_e;

  // Completion rule for one poll read, given the sampled status bit.
  function automatic logic dp_complete(input logic is_erase,
                                       input logic want,
                                       input logic got);
    return is_erase ? got : (got == want);
  endfunction

endpackage

// File: rtl/dpoll_gap_timer.sv
module dpoll_gap_timer #(
  parameter int GAP_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int GW = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC + 1);
  localparam logic [GW-1:0] LAST = GW'(GAP_CYC - 1);

  logic [GW-1:0] cnt_q;

  assign expired = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (load)     cnt_q <= '0;
    else if (run && !expired) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dpoll_budget.sv
module dpoll_budget #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  input  logic             bump,
  output logic             last_read
);
  localparam int EW = CNT_W + 1;

  logic [CNT_W-1:0] used_q;
  logic [CNT_W-1:0] lim_q;
  logic [EW-1:0]    eff_lim;
  logic [EW-1:0]    after;

  assign eff_lim   = (lim_q == '0) ? EW'(1) : {1'b0, lim_q};
  assign after     = {1'b0, used_q} + EW'(1);
  assign last_read = (after >= eff_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
      lim_q  <= '0;
    end else if (clear) begin
      used_q <= '0;
      lim_q  <= limit;
    end else if (bump && !(&used_q)) begin
      used_q <= used_q + 1'b1;
    end
  end
endmodule

// File: rtl/datapoll_host_ctrl.sv
module datapoll_host_ctrl
  import dpoll_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 16,
  parameter int GAP_CYC  = 2,
  parameter int FLAG_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic              start_erase,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              start_want,
  input  logic [CNT_W-1:0]  poll_limit,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rvalid,
  input  logic [DATA_W-1:0] rd_rdata,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  output logic              res_timeout
);
  dp_state_e st_q, st_d;

  logic              erase_q, want_q, confirm_q, res_to_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] res_q;
  logic accept, resp, poll_resp, done_hit, last_read, gap_over, gap_load;

  assign start_ready = (st_q == DP_IDLE);
  assign accept      = start_valid && start_ready;
  assign resp        = (st_q == DP_WAIT) && rd_rvalid;
  assign poll_resp   = resp && !confirm_q;
  assign done_hit    = dp_complete(erase_q, want_q, rd_rdata[FLAG_BIT]);
  assign gap_load    = resp && (st_d == DP_GAP);

  assign rd_req      = (st_q == DP_REQ);
  assign rd_addr     = addr_q;
  assign res_valid   = (st_q == DP_DONE);
  assign res_data    = res_q;
  assign res_timeout = res_to_q;

  dpoll_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load),
    .run(st_q == DP_GAP), .expired(gap_over)
  );

  dpoll_budget #(.CNT_W(CNT_W)) u_budget (
    .clk(clk), .rst_n(rst_n), .clear(accept), .limit(poll_limit),
    .bump(poll_resp), .last_read(last_read)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      DP_IDLE: if (accept) st_d = DP_REQ;
      DP_REQ:  st_d = DP_WAIT;
      DP_WAIT: begin
        if (resp) begin
          if (confirm_q)      st_d = DP_DONE;
          else if (done_hit)  st_d = DP_GAP;
          else if (last_read) st_d = DP_DONE;
          else                st_d = DP_GAP;
        end
      end
      DP_GAP:  if (gap_over) st_d = DP_REQ;
      DP_DONE: if (res_ready) st_d = DP_IDLE;
      default: st_d = DP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= DP_IDLE;
      erase_q   <= 1'b0;
      want_q    <= 1'b0;
      confirm_q <= 1'b0;
      addr_q    <= '0;
      res_q     <= '0;
      res_to_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        erase_q   <= start_erase;
        want_q    <= start_want;
        addr_q    <= start_addr;
        confirm_q <= 1'b0;
      end
      if (poll_resp && done_hit) confirm_q <= 1'b1;
      if (resp && confirm_q) begin
        res_q    <= rd_rdata;
        res_to_q <= 1'b0;
      end else if (poll_resp && !done_hit && last_read) begin
        res_q    <= '0;
        res_to_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/datapoll_host_chk.sv
module datapoll_host_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_valid,
  input logic              start_ready,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_rvalid,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_data,
  input logic              res_timeout
);
  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> !rd_req);

  a_r2_first_read: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid && start_ready |=> rd_req);

  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !start_ready && $past(!start_ready) |-> $stable(rd_addr));

  a_r3_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  a_r7_gap_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rvalid |=> !rd_req);

  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_timeout));

  a_r9_no_read_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !rd_req);
endmodule

bind datapoll_host_ctrl datapoll_host_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
  .rd_req(rd_req), .rd_addr(rd_addr), .rd_rvalid(rd_rvalid), .res_valid(res_valid),
  .res_ready(res_ready), .res_data(res_data), .res_timeout(res_timeout)
);

// File: tb/sim_datapoll_host_ctrl.sv
`timescale 1ns/1ps
module sim_datapoll_host_ctrl;
  localparam int GAP = 2;
  localparam int LAT = 2;

  logic clk = 0, rst_n = 0;
  logic start_valid = 0, start_erase = 0, start_want = 0;
  logic [23:0] start_addr = '0;
  logic [15:0] poll_limit = '0;
  logic start_ready, rd_req, res_valid, res_timeout;
  logic [23:0] rd_addr;
  logic rd_rvalid = 0;
  logic [15:0] rd_rdata = '0;
  logic res_ready = 0;
  logic [15:0] res_data;

  int total = 0, bad = 0;
  int req_seen = 0;
  logic [15:0] resp_q [$];

  // behavioural reference model
  bit m_busy = 0, m_confirm = 0, m_res = 0, m_res_to = 0, m_erase = 0, m_want = 0;
  int m_req_in = -1, m_polls = 0, m_limit = 1, mem_cnt = 0;
  logic [23:0] m_addr = '0;
  logic [15:0] m_res_data = '0;

  always #10 clk = ~clk;

  datapoll_host_ctrl #(.ADDR_W(24), .DATA_W(16), .CNT_W(16), .GAP_CYC(GAP), .FLAG_BIT(7)) u0 (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_erase(start_erase), .start_addr(start_addr), .start_want(start_want),
    .poll_limit(poll_limit), .rd_req(rd_req), .rd_addr(rd_addr), .rd_rvalid(rd_rvalid),
    .rd_rdata(rd_rdata), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_timeout(res_timeout)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_confirm = 0; m_res = 0; m_req_in = -1; mem_cnt = 0;
      rd_rvalid = 0;
    end else begin
      bit exp_req, got7, fin;
      exp_req = m_busy && (m_req_in == 0);
      chk(start_ready == !m_busy, "R2 start_ready", start_ready, !m_busy);
      chk(rd_req == exp_req, "R7 rd_req timing", rd_req, exp_req);
      if (rd_req && exp_req) chk(rd_addr == m_addr, "R3 rd_addr", rd_addr, m_addr);
      chk(res_valid == m_res, "R9 res_valid", res_valid, m_res);
      if (res_valid && m_res) begin
        chk(res_data == m_res_data, "R6 res_data", res_data, m_res_data);
        chk(res_timeout == m_res_to, "R8 res_timeout", res_timeout, m_res_to);
      end
      // memory: respond LAT cycles after request
      rd_rvalid = 0;
      if (mem_cnt > 0) begin
        mem_cnt--;
        if (mem_cnt == 0) begin
          rd_rvalid = 1;
          rd_rdata = (resp_q.size() > 0) ? resp_q.pop_front() : 16'h0000;
        end
      end
      if (rd_req) begin mem_cnt = LAT; req_seen++; end
      // model advance
      if (exp_req) m_req_in = -1;
      else if (m_req_in > 0) m_req_in--;
      if (rd_rvalid && m_busy) begin
        if (m_confirm) begin
          m_res = 1; m_res_data = rd_rdata; m_res_to = 0;
        end else begin
          m_polls++;
          got7 = rd_rdata[7];
          fin = m_erase ? (got7 == 1'b1) : (got7 == m_want);
          if (fin) begin m_confirm = 1; m_req_in = GAP; end
          else if (m_polls >= m_limit) begin m_res = 1; m_res_data = 0; m_res_to = 1; end
          else m_req_in = GAP;
        end
      end
      if (start_valid && !m_busy) begin
        m_busy = 1; m_req_in = 0; m_polls = 0; m_confirm = 0;
        m_erase = start_erase; m_want = start_want; m_addr = start_addr;
        m_limit = (poll_limit == 0) ? 1 : int'(poll_limit);
      end else if (m_res && res_ready) begin
        m_res = 0; m_busy = 0;
      end
    end
  end

  task automatic run_op(input bit er, input logic [23:0] a, input bit w, input int lim,
                        input int dly, input logic [15:0] ed, input bit eto,
                        input int nrd, input string tag);
    int r0;
    logic [15:0] gd;
    bit gto;
    @(posedge clk); #1;
    while (!start_ready) begin @(posedge clk); #1; end
    start_valid = 1; start_erase = er; start_addr = a; start_want = w;
    poll_limit = lim[15:0];
    r0 = req_seen;
    @(posedge clk); #1;
    start_valid = 0;
    while (!res_valid) begin @(posedge clk); #1; end
    repeat (dly) begin @(posedge clk); #1; end
    gd = res_data; gto = res_timeout;
    res_ready = 1;
    @(posedge clk); #1;
    res_ready = 0;
    chk(gd == ed, {tag, " result word"}, gd, ed);
    chk(gto == eto, {tag, " timeout flag"}, gto, eto);
    chk(req_seen - r0 == nrd, {tag, " read count"}, req_seen - r0, nrd);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(start_ready == 1, "R1 reset start_ready", start_ready, 1);
    chk(rd_req == 0, "R1 reset rd_req", rd_req, 0);
    chk(res_valid == 0, "R1 reset res_valid", res_valid, 0);

    // R4 R6: program, want 0; bit 7 clears on 3rd read; confirm word returned.
    // A start during polling must be dropped (R2).
    resp_q = '{16'h00FF, 16'h0080, 16'h1200, 16'h1234};
    fork
      run_op(0, 24'h012340, 0, 8, 0, 16'h1234, 0, 4, "R4 R6 program");
      begin
        repeat (4) begin @(posedge clk); #1; end
        start_valid = 1; start_addr = 24'h777777;
        @(posedge clk); #1;
        start_valid = 0;
      end
    join

    // R4 R9: program, want 1, result held under back-pressure
    resp_q = '{16'h0042, 16'hFFFF, 16'hABCD};
    run_op(0, 24'h00BEEF, 1, 8, 3, 16'hABCD, 0, 3, "R4 R9 program backpressure");

    // R5: erase, want bit ignored
    resp_q = '{16'h0000, 16'h007F, 16'h0080, 16'hFFFF};
    run_op(1, 24'h3F0000, 0, 8, 1, 16'hFFFF, 0, 4, "R5 erase");

    // R8: timeout after 3 reads
    resp_q = '{16'h0000, 16'h0000, 16'h0000};
    run_op(0, 24'h000100, 1, 3, 0, 16'h0000, 1, 3, "R8 timeout");

    // R8: completion on last allowed read wins
    resp_q = '{16'h0000, 16'h0000, 16'h0080, 16'h5A5A};
    run_op(0, 24'h000200, 1, 3, 0, 16'h5A5A, 0, 4, "R8 last read completes");

    // R8: limit 0 acts as 1
    resp_q = '{16'h0000};
    run_op(0, 24'h000300, 1, 0, 2, 16'h0000, 1, 1, "R8 zero limit");

    // R7: longer poll with several gaps
    resp_q = '{16'h0080, 16'h0080, 16'h0080, 16'h0080, 16'h0000, 16'hC3C3};
    run_op(0, 24'h0A0A0A, 0, 16, 0, 16'hC3C3, 0, 6, "R7 gap series");

    repeat (5) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule